// File: doc/BRIEF.md
# Dual 32-bit Split Timer

This block is a timer peripheral with a 64-bit counting resource that runs as two independent 32-bit halves, a low half and a high half. Each half owns a counter, a period, a two-bit run-mode field, a reset-release bit and an interrupt line. Software reaches all of this through a word-addressed register bus. Writes land on the rising clock edge. Reads are combinational.

A half counts only in cycles where the shared `tick_en` input is high. Its counter moves up by one on each such cycle until it equals the period. At that point the half raises its interrupt for one cycle. In continuous mode the counter then restarts at zero. In one-shot mode the counter stays at the period and the half's mode field drops back to disabled.

Setting the period to all ones in continuous mode turns a half into a free-running cycle counter. Software can overwrite a counter at any time, for example to clear it.

Top module: `dual_split_timer`

## Requirements
- R1: Registers sit at word indices 4 (low counter), 5 (high counter), 6 (low period), 7 (high period), 8 (mode control) and 9 (global control); byte offsets are four times these. Counters and periods read back what was last written, and unmapped indices read 0 and ignore writes.
- R2: The mode control word keeps only bits 7:6 (low-half mode) and bits 23:22 (high-half mode), and all its other bits read 0. The mode values are: 0 disabled, 1 one-shot, 2 continuous.
- R3: A released half in mode 1 or 2 whose counter is below its period adds one to its counter on each cycle with `tick_en` high, and does not change in cycles with `tick_en` low.
- R4: In continuous mode, a tick that finds the counter equal to the period sets the counter to 0. In the next cycle it drives that half's interrupt high for exactly that one cycle.
- R5: In one-shot mode, a tick that finds the counter equal to the period pulses the interrupt once, leaves the counter at the period, and sets the half's mode field to 0. After that the half does not count again.
- R6: Mode 0 and the reserved mode 3 both stop counting and keep the current counter value.
- R7: Global control bit 0 (low half) and bit 1 (high half) hold their half in reset while 0, and all global control bits reset to 0. A half held in reset keeps its counter at 0, ignores counter writes and its mode field, and raises no interrupt. Writing 1 releases it, and its period stays readable and writable throughout.
- R8: Global control bit 2 (split select, 1 = two unchained 32-bit timers) is stored and read back. Global control bits above bit 2 read 0.
- R9: The two halves count, expire and interrupt independently of each other, on separate interrupt outputs.
- R10: A software write to a released counter takes effect in the cycle it is made and wins over a tick in that same cycle.
- R11: With a period of 0xFFFFFFFF in continuous mode, the counter passes 0xFFFFFFFE, 0xFFFFFFFF, 0, 1 on successive ticks, and pulses the interrupt once at the wrap.
- R12: After reset, every register reads 0 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable shared by both halves |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_lo | output | 1 | Low-half expiry pulse |
| irq_hi | output | 1 | High-half expiry pulse |

## Verification
The hardest case to reach from the ports is a collision in a single clock cycle. One kind is a counter write landing on the same edge as a tick. The other is a one-shot expiry landing on the same edge as the hardware clearing the mode field. The bench reaches the first by holding `tick_en` high through the write strobe and then reading the counter after the tick has been dropped. It drives the wrap cases by preloading the counter one or two steps below the period, so an all-ones period wraps after a few ticks instead of four billion. It counts interrupt samples across every tick window, so a pulse that is missed or stretched shows up in the count.

// File: rtl/dst_pkg.sv
// Package: shared constants and types for the dual split timer.
// Assumes exactly two halves (low = 0, high = 1) and a word-indexed register bus.
package dst_pkg;
    localparam int NUM_HALVES    = 2;
    localparam int MODE_W        = 2;
    localparam int CNT_IDX_BASE  = 4;   // counter of half h at CNT_IDX_BASE + h
    localparam int PRD_IDX_BASE  = 6;   // period of half h at PRD_IDX_BASE + h
    localparam int TCR_IDX       = 8;   // mode control word
    localparam int GCR_IDX       = 9;   // global control word
    localparam int MODE_LSB_BASE = 6;   // low half mode field LSB
    localparam int MODE_LSB_STEP = 16;  // distance to the high half field
    localparam int GCR_BITS      = 3;   // release lo, release hi, split select

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF  = 2'd0,
        MODE_ONCE = 2'd1,
        MODE_LOOP = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;
endpackage

// File: rtl/dst_half.sv
// Module: one 32-bit timer half. Holds counter and period, counts on tick_en,
// raises a one-cycle interrupt on reaching the period and reports one-shot expiry.
// Assumes the register block owns the mode field and reset-release bit.
module dst_half
    import dst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              release_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              cnt_wr_i,
    input  logic              prd_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] prd_o,
    output logic              irq_o,
    output logic              done_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] cnt_q, prd_q;
    logic              irq_q;
    logic              run, hit, is_loop;

    // Decode whether this half is allowed to count this cycle.
    always_comb begin
        is_loop = (mode_i == MODE_LOOP);
        run     = release_i && ((mode_i == MODE_ONCE) || is_loop);
        hit     = run && tick_en && !cnt_wr_i && (cnt_q == prd_q);
    end

    // Counter: reset hold, software write, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !release_i) begin
            cnt_q <= '0;
        end else if (cnt_wr_i) begin
            cnt_q <= wdata_i;
        end else if (run && tick_en) begin
            if (hit) begin
                cnt_q <= is_loop ? '0 : cnt_q;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // Period register, writable regardless of the reset-release bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_q <= '0;
        end else if (prd_wr_i) begin
            prd_q <= wdata_i;
        end
    end

    // Registered one-cycle interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
        end
    end

    assign cnt_o  = cnt_q;
    assign prd_o  = prd_q;
    assign irq_o  = irq_q;
    assign done_o = hit && (mode_i == MODE_ONCE);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && (mode_i == MODE_ONCE || mode_i == MODE_LOOP) && tick_en
         && !cnt_wr_i && cnt_q != prd_q) |=> (cnt_q == $past(cnt_q) + ONE));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !tick_en && !cnt_wr_i) |=> $stable(cnt_q));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && mode_i == MODE_LOOP && tick_en && !cnt_wr_i && cnt_q == prd_q)
        |=> (cnt_q == '0 && irq_o));

    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(tick_en && release_i && cnt_q == prd_q));

    p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && (mode_i == MODE_OFF || mode_i == MODE_RSVD) && !cnt_wr_i)
        |=> $stable(cnt_q));

    p_held_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !release_i |=> (cnt_q == '0 && !irq_o));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && cnt_wr_i) |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/dst_regs.sv
// Module: register decode for the dual split timer. Owns the mode control and
// global control words, steers counter/period writes to the halves and muxes reads.
// Assumes one-shot expiry from a half clears its mode field unless software writes
// the mode control word in the same cycle.
module dst_regs
    import dst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_wr,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [DATA_W-1:0]                     bus_wdata,
    input  logic [NUM_HALVES-1:0][DATA_W-1:0]     cnt_i,
    input  logic [NUM_HALVES-1:0][DATA_W-1:0]     prd_i,
    input  logic [NUM_HALVES-1:0]                 done_i,
    output logic [NUM_HALVES-1:0][MODE_W-1:0]     mode_o,
    output logic [NUM_HALVES-1:0]                 release_o,
    output logic [NUM_HALVES-1:0]                 cnt_wr_o,
    output logic [NUM_HALVES-1:0]                 prd_wr_o,
    output logic [DATA_W-1:0]                     rdata_o
);
    // Build the mask of writable mode-field bits.
    function automatic logic [DATA_W-1:0] tcr_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int h = 0; h < NUM_HALVES; h++) begin
            m[MODE_LSB_BASE + h*MODE_LSB_STEP +: MODE_W] = '1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] TCR_MASK = tcr_mask_f();
    localparam logic [DATA_W-1:0] GCR_MASK = DATA_W'((1 << GCR_BITS) - 1);

    logic [DATA_W-1:0] tcr_q, tcr_next, gcr_q;
    logic              tcr_wr, gcr_wr;
    int                idx;

    // Address decode for the shared words and per-half strobes.
    always_comb begin
        idx    = int'(bus_addr);
        tcr_wr = bus_wr && (idx == TCR_IDX);
        gcr_wr = bus_wr && (idx == GCR_IDX);
        for (int h = 0; h < NUM_HALVES; h++) begin
            cnt_wr_o[h] = bus_wr && (idx == CNT_IDX_BASE + h);
            prd_wr_o[h] = bus_wr && (idx == PRD_IDX_BASE + h);
        end
    end

    // Next mode control word: expiry clears a field, a software write wins.
    always_comb begin
        tcr_next = tcr_q;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (done_i[h]) begin
                tcr_next[MODE_LSB_BASE + h*MODE_LSB_STEP +: MODE_W] = '0;
            end
        end
        if (tcr_wr) begin
            tcr_next = bus_wdata & TCR_MASK;
        end
    end

    // Mode control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcr_q <= '0;
        end else begin
            tcr_q <= tcr_next;
        end
    end

    // Global control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcr_q <= '0;
        end else if (gcr_wr) begin
            gcr_q <= bus_wdata & GCR_MASK;
        end
    end

    // Per-half fields taken from the control words.
    always_comb begin
        for (int h = 0; h < NUM_HALVES; h++) begin
            mode_o[h]    = tcr_q[MODE_LSB_BASE + h*MODE_LSB_STEP +: MODE_W];
            release_o[h] = gcr_q[h];
        end
    end

    // Read mux; unmapped indices return zero.
    always_comb begin
        rdata_o = '0;
        if (idx == TCR_IDX) rdata_o = tcr_q;
        if (idx == GCR_IDX) rdata_o = gcr_q;
        for (int h = 0; h < NUM_HALVES; h++) begin
            if (idx == CNT_IDX_BASE + h) rdata_o = cnt_i[h];
            if (idx == PRD_IDX_BASE + h) rdata_o = prd_i[h];
        end
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_chk
        p_once_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i[g] && !tcr_wr) |=> (mode_o[g] == MODE_OFF));
    end

    p_gcr_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gcr_q & ~GCR_MASK) == '0);
endmodule

// File: rtl/dual_split_timer.sv
// Module: top of the dual split timer. Instantiates the register block and
// one timer half per generate iteration, and brings out the two interrupts.
// Assumes a synchronous active-low reset and a single shared count enable.
module dual_split_timer
    import dst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [NUM_HALVES-1:0][DATA_W-1:0] cnt, prd;
    logic [NUM_HALVES-1:0][MODE_W-1:0] mode;
    logic [NUM_HALVES-1:0]             done, rel, cnt_wr, prd_wr, irq;

    dst_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_i     (cnt),
        .prd_i     (prd),
        .done_i    (done),
        .mode_o    (mode),
        .release_o (rel),
        .cnt_wr_o  (cnt_wr),
        .prd_wr_o  (prd_wr),
        .rdata_o   (bus_rdata)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        dst_half #(.DATA_W(DATA_W)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .release_i (rel[h]),
            .mode_i    (mode[h]),
            .cnt_wr_i  (cnt_wr[h]),
            .prd_wr_i  (prd_wr[h]),
            .wdata_i   (bus_wdata),
            .cnt_o     (cnt[h]),
            .prd_o     (prd[h]),
            .irq_o     (irq[h]),
            .done_o    (done[h])
        );
    end

    assign irq_lo = irq[0];
    assign irq_hi = irq[1];

    p_irq_reset_r12: assert property (@(posedge clk)
        !rst_n |=> (!irq_lo && !irq_hi));
endmodule

// File: tb/dual_split_timer_tb.sv
`timescale 1ns/1ps
module dual_split_timer_tb;
    localparam logic [3:0] A_CLO = 4'd4, A_CHI = 4'd5, A_PLO = 4'd6, A_PHI = 4'd7;
    localparam logic [3:0] A_TCR = 4'd8, A_GCR = 4'd9;
    localparam int NVEC = 10;
    // {index, write data, expected read-back}
    localparam logic [67:0] VEC [NVEC] = '{
        {A_PLO, 32'h1234_5678, 32'h1234_5678},   // R1
        {A_PHI, 32'hCAFE_F00D, 32'hCAFE_F00D},   // R1
        {A_TCR, 32'hFFFF_FFFF, 32'h00C0_00C0},   // R2
        {A_TCR, 32'h0040_0080, 32'h0040_0080},   // R2
        {A_GCR, 32'hFFFF_FFF8, 32'h0000_0000},   // R8
        {A_GCR, 32'h0000_0004, 32'h0000_0004},   // R8
        {A_CLO, 32'h0000_ABCD, 32'h0000_0000},   // R7 held
        {A_CHI, 32'h0000_1111, 32'h0000_0000},   // R7 held
        {4'd0,  32'hFFFF_FFFF, 32'h0000_0000},   // R1 unmapped
        {4'd15, 32'hFFFF_FFFF, 32'h0000_0000}    // R1 unmapped
    };

    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq_lo, irq_hi;
    int          n_chk = 0, n_fail = 0, irq_lo_n = 0, irq_hi_n = 0;

    always #2.5 clk = ~clk;

    dual_split_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    // Hold tick_en high for n edges, counting interrupt samples after each edge.
    task automatic run(input int n);
        irq_lo_n = 0; irq_hi_n = 0;
        @(negedge clk); tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_lo) irq_lo_n++;
            if (irq_hi) irq_hi_n++;
        end
        tick_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        for (int a = 4; a <= 9; a++) rd_chk(4'(a), 32'h0, "R12 reset regs");
        check(!irq_lo && !irq_hi, "R12 irq low", {30'b0, irq_hi, irq_lo}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v][67:64], VEC[v][63:32]);
            rd_chk(VEC[v][67:64], VEC[v][31:0], "R1/R2/R7/R8 vector");
        end
        wr(A_TCR, 32'h0);

        // R3: gating by tick_en
        wr(A_GCR, 32'h7); wr(A_PLO, 32'd100); wr(A_CLO, 32'd0); wr(A_TCR, 32'h80);
        repeat (5) @(negedge clk);
        rd_chk(A_CLO, 32'd0, "R3 no tick no count");
        run(4);
        rd_chk(A_CLO, 32'd4, "R3 count per tick");

        // R4: continuous wrap
        wr(A_CLO, 32'd0); wr(A_PLO, 32'd3);
        run(10);
        rd_chk(A_CLO, 32'd2, "R4 cont counter");
        check(irq_lo_n == 2, "R4 cont irq pulses", irq_lo_n, 2);

        // R10: write coincides with a tick
        wr(A_PLO, 32'd1000); wr(A_CLO, 32'd0);
        @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_CLO; bus_wdata = 32'h50;
        @(negedge clk); tick_en = 1'b0; bus_wr = 1'b0;
        rd_chk(A_CLO, 32'h50, "R10 write beats tick");

        // R5: one-shot
        wr(A_CLO, 32'd0); wr(A_PLO, 32'd5); wr(A_TCR, 32'h40);
        run(20);
        rd_chk(A_CLO, 32'd5, "R5 oneshot holds period");
        check(irq_lo_n == 1, "R5 oneshot single irq", irq_lo_n, 1);
        rd_chk(A_TCR, 32'h0, "R5 mode cleared");

        // R6: disabled and reserved modes
        wr(A_CLO, 32'd7); wr(A_TCR, 32'h0);
        run(10);
        rd_chk(A_CLO, 32'd7, "R6 mode0 holds");
        wr(A_TCR, 32'hC0);
        run(10);
        rd_chk(A_CLO, 32'd7, "R6 mode3 holds");

        // R7: reset hold of low half
        wr(A_TCR, 32'h80); wr(A_GCR, 32'h6);
        run(5);
        rd_chk(A_CLO, 32'd0, "R7 held counter zero");
        check(irq_lo_n == 0, "R7 held no irq", irq_lo_n, 0);
        rd_chk(A_PLO, 32'd5, "R7 period kept");
        wr(A_GCR, 32'h7);
        run(3);
        rd_chk(A_CLO, 32'd3, "R7 released counts");

        // R9: independent halves
        wr(A_TCR, 32'h0);
        wr(A_PLO, 32'd2); wr(A_CLO, 32'd0); wr(A_PHI, 32'd4); wr(A_CHI, 32'd0);
        wr(A_TCR, 32'h0040_0080);
        run(12);
        rd_chk(A_CLO, 32'd0, "R9 low counter");
        check(irq_lo_n == 4, "R9 low irqs", irq_lo_n, 4);
        rd_chk(A_CHI, 32'd4, "R9 high counter");
        check(irq_hi_n == 1, "R9 high irqs", irq_hi_n, 1);
        rd_chk(A_TCR, 32'h80, "R9 only high mode cleared");

        // R11: free-running wrap of the high half
        wr(A_TCR, 32'h0);
        wr(A_PHI, 32'hFFFF_FFFF); wr(A_CHI, 32'hFFFF_FFFE); wr(A_TCR, 32'h0080_0000);
        run(1);
        rd_chk(A_CHI, 32'hFFFF_FFFF, "R11 reaches all ones");
        run(2);
        rd_chk(A_CHI, 32'd1, "R11 wraps to zero");
        check(irq_hi_n == 1, "R11 wrap irq", irq_hi_n, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule